// File: doc/BRIEF.md
# Bus-to-PCI Read Request Sequencer

This block steers the read side of a bridge between a processor-local bus and PCI. A local-bus master presents a read with an address, a single-word or line (eight-word) length flag and a flag for a supported command. The top address bits pick the target space: PCI memory, PCI I/O, PCI configuration, interrupt acknowledge, or the bridge's own register file. A claimed read is held off with a wait indication. The sequencer then empties the posted-write path, requests the PCI bus, gathers the read words from a simple PCI master handshake, acknowledges the address and returns the data beats in address order.

Line reads are normally acknowledged only once the whole line is buffered, so a target that disconnects partway cannot split the local-bus transfer. After such a disconnect the PCI read is reissued at the next word. An early-acknowledge option acknowledges a line read on its first PCI word and streams the rest as they arrive. In that mode a target disconnect leaves the read waiting forever, so the option is only safe when targets never disconnect. A master abort turns every returned beat into all ones. Reads of the bridge's own registers skip both the posted-write drain and PCI, and their data comes from `cfg_rdata`.

Top module: `pci_read_sequencer`

## Requirements
- R1: The space is chosen by `rd_addr[31:28]`: 0x8 memory, 0xE I/O, 0xC PCI configuration, 0xD interrupt acknowledge, 0xF bridge registers. A read is claimed only if the tag matches one of these, `rd_cmd_ok` is 1, and `rd_line` is 0 or the tag is memory. Any other read draws no wait, no acknowledge and no PCI request.
- R2: `rd_wait` is high in the first cycle after a claimed request is sampled. `rd_addr_ack` is never given without a preceding wait cycle.
- R3: `pci_req` is never asserted while `posted_pending` is high. Every PCI read starts only after the posted writes have drained.
- R4: With `early_ack_en` at 0, a line read is acknowledged only after all eight words have been captured from PCI.
- R5: With `early_ack_en` at 1, a line read is acknowledged right after its first PCI word. Later words are returned as they arrive.
- R6: If the PCI cycle ends with `pci_mabort`, every returned beat (one for a single read, eight for a line) is 32'hFFFF_FFFF.
- R7: A bridge-register read is acknowledged in the second cycle after its request even while `posted_pending` is high. It runs no PCI cycle and returns one beat equal to `cfg_rdata`.
- R8: While `pci_cyc` is high, `pci_addr` equals the read address plus four times the number of words already captured, and `pci_count` equals the words still missing. A disconnect before the line is complete makes the sequencer request the bus again and continue at the next word.
- R9: After the acknowledge, beats come one per cycle in which `rd_data_vld` is high, in ascending word order, with `rd_data` for word i carrying the PCI data of address base+4i. After the last beat the block is idle, with wait, acknowledge and data valid low, as it is after reset.
- R10: `pci_space` encodes the space as 0 memory, 1 I/O, 2 configuration, 3 interrupt acknowledge while `pci_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Local-bus read request, held until acknowledged |
| rd_addr | input | 32 | Read byte address |
| rd_line | input | 1 | 1 for an eight-word line read, 0 for a single word |
| rd_cmd_ok | input | 1 | Command type is supported |
| early_ack_en | input | 1 | Acknowledge line reads on the first PCI word |
| posted_pending | input | 1 | Posted writes still waiting to reach PCI |
| cfg_rdata | input | 32 | Bridge register read data |
| rd_wait | output | 1 | Read claimed, acknowledge pending |
| rd_addr_ack | output | 1 | Address acknowledge, one cycle |
| rd_data_vld | output | 1 | Read data beat valid |
| rd_data | output | 32 | Read data beat |
| pci_req | output | 1 | PCI bus request |
| pci_gnt | input | 1 | PCI bus grant |
| pci_cyc | output | 1 | PCI read cycle in progress |
| pci_addr | output | 32 | Address of the next PCI word |
| pci_space | output | 2 | PCI space of the read |
| pci_count | output | 4 | Words still needed |
| pci_rvalid | input | 1 | PCI read word valid |
| pci_rdata | input | 32 | PCI read word |
| pci_disc | input | 1 | Target disconnects after this word |
| pci_mabort | input | 1 | PCI cycle ended by master abort |

## Verification
The block is driven with reads that hit each of the five tags and with reads that must be refused: an unmapped tag, an unsupported command, and a line read outside memory. Line reads go through in both acknowledge modes. Counting the PCI words captured before the acknowledge is what separates buffered-line behaviour from early acknowledge. Disconnects after three words check that reissued cycles carry the right address and word count, and that the reassembled data lands in the right order. Master aborts on single and line reads, and bridge-register reads with writes still posted, show that all-ones substitution and the drain bypass are keyed to the right condition. The randomised mix adds grant and data gaps plus posted-write delays of varied length.

// File: rtl/rdseq_pkg.sv
`timescale 1ns/1ps
package rdseq_pkg;

  typedef enum logic [1:0] {
    SPC_MEM  = 2'd0,
    SPC_IO   = 2'd1,
    SPC_CFG  = 2'd2,
    SPC_IACK = 2'd3
  } spc_e;

  typedef enum logic [6:0] {
    S_IDLE  = 7'b0000001,
    S_CLAIM = 7'b0000010,
    S_DRAIN = 7'b0000100,
    S_ARB   = 7'b0001000,
    S_FILL  = 7'b0010000,
    S_ACK   = 7'b0100000,
    S_RET   = 7'b1000000
  } seq_st_e;

endpackage

// File: rtl/rdseq_decode.sv
`timescale 1ns/1ps
module rdseq_decode
  import rdseq_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              TAG_W    = 4,
  parameter logic [TAG_W-1:0] MEM_TAG  = 4'h8,
  parameter logic [TAG_W-1:0] IO_TAG   = 4'hE,
  parameter logic [TAG_W-1:0] CFG_TAG  = 4'hC,
  parameter logic [TAG_W-1:0] IACK_TAG = 4'hD,
  parameter logic [TAG_W-1:0] OWN_TAG  = 4'hF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              line,
  input  logic              cmd_ok,
  output logic              claim,
  output logic              own,
  output spc_e              space
);

  logic [TAG_W-1:0] tag;
  logic             hit;

  always_comb begin
    tag   = addr[ADDR_W-1 -: TAG_W];
    hit   = 1'b1;
    own   = 1'b0;
    space = SPC_MEM;
    if (tag == MEM_TAG)       space = SPC_MEM;
    else if (tag == IO_TAG)   space = SPC_IO;
    else if (tag == CFG_TAG)  space = SPC_CFG;
    else if (tag == IACK_TAG) space = SPC_IACK;
    else if (tag == OWN_TAG)  own   = 1'b1;
    else                      hit   = 1'b0;
    // line transfers exist only toward PCI memory
    claim = hit && cmd_ok && (!line || (tag == MEM_TAG));
  end

endmodule

// File: rtl/rdseq_collect.sv
`timescale 1ns/1ps
module rdseq_collect #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = $clog2(LINE_WORDS + 1),
  parameter int IDX_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              arm,
  input  logic [CNT_W-1:0]  need,
  input  logic              pci_rvalid,
  input  logic [DATA_W-1:0] pci_rdata,
  input  logic              pci_disc,
  input  logic              pci_mabort,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              active,
  output logic [CNT_W-1:0]  wcnt,
  output logic              aborted,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0]     line_buf [LINE_WORDS];
  logic [LINE_WORDS-1:0] wen;
  logic                  beat;
  logic                  cyc_end;

  assign beat    = active && pci_rvalid;
  assign cyc_end = beat && (((wcnt + CNT_W'(1)) == need) || pci_disc);
  assign rd_word = line_buf[rd_idx];

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_wen
    assign wen[g] = beat && (wcnt == CNT_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINE_WORDS; i++) begin
      if (wen[i]) line_buf[i] <= pci_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wcnt    <= '0;
      aborted <= 1'b0;
    end else if (clear) begin
      active  <= 1'b0;
      wcnt    <= '0;
      aborted <= 1'b0;
    end else begin
      if (arm) active <= 1'b1;
      if (beat) wcnt <= wcnt + CNT_W'(1);
      if (active && pci_mabort) begin
        aborted <= 1'b1;
        active  <= 1'b0;
      end
      if (cyc_end) active <= 1'b0;
    end
  end

endmodule

// File: rtl/rdseq_ctrl.sv
`timescale 1ns/1ps
module rdseq_ctrl
  import rdseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = $clog2(LINE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              dec_claim,
  input  logic              dec_own,
  input  spc_e              dec_spc,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_line,
  input  logic              early_ack_en,
  input  logic              posted_pending,
  input  logic              pci_gnt,
  input  logic              pci_rvalid,
  input  logic              pci_disc,
  input  logic              pci_mabort,
  input  logic [CNT_W-1:0]  wcnt,
  input  logic              aborted,
  output seq_st_e           st,
  output logic              col_clear,
  output logic              col_arm,
  output logic              rd_wait,
  output logic              rd_addr_ack,
  output logic              ret_vld,
  output logic [CNT_W-1:0]  rcnt,
  output logic [CNT_W-1:0]  need,
  output logic [ADDR_W-1:0] addr_q,
  output spc_e              spc_q,
  output logic              line_q,
  output logic              own_q,
  output logic              early_q
);

  seq_st_e          st_nxt;
  logic [CNT_W-1:0] wnext;
  logic [CNT_W-1:0] rnext;

  always_comb begin
    need        = line_q ? CNT_W'(LINE_WORDS) : CNT_W'(1);
    wnext       = wcnt + CNT_W'(1);
    rnext       = rcnt + CNT_W'(1);
    col_clear   = (st == S_IDLE) && rd_req && dec_claim;
    col_arm     = (st == S_ARB) && pci_gnt;
    rd_wait     = (st == S_CLAIM) || (st == S_DRAIN) || (st == S_ARB) || (st == S_FILL);
    rd_addr_ack = (st == S_ACK);
    ret_vld     = (st == S_RET) && (own_q || aborted || (rcnt < wcnt));
    st_nxt      = st;
    unique case (st)
      S_IDLE:  if (col_clear) st_nxt = S_CLAIM;
      S_CLAIM: st_nxt = own_q ? S_ACK : S_DRAIN;
      S_DRAIN: if (!posted_pending) st_nxt = S_ARB;
      S_ARB:   if (pci_gnt) st_nxt = S_FILL;
      S_FILL: begin
        if (pci_mabort) st_nxt = S_ACK;
        else if (pci_rvalid) begin
          if ((early_q && line_q) || (wnext == need)) st_nxt = S_ACK;
          else if (pci_disc)                           st_nxt = S_ARB;
        end
      end
      S_ACK:   st_nxt = S_RET;
      S_RET:   if (ret_vld && (rnext == need)) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      spc_q   <= SPC_MEM;
      line_q  <= 1'b0;
      own_q   <= 1'b0;
      early_q <= 1'b0;
      rcnt    <= '0;
    end else if (col_clear) begin
      addr_q  <= rd_addr;
      spc_q   <= dec_spc;
      line_q  <= rd_line;
      own_q   <= dec_own;
      early_q <= early_ack_en;
      rcnt    <= '0;
    end else if (ret_vld) begin
      rcnt    <= rnext;
    end
  end

endmodule

// File: rtl/pci_read_sequencer.sv
`timescale 1ns/1ps
module pci_read_sequencer
  import rdseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 4,
  localparam int CNT_W     = $clog2(LINE_WORDS + 1),
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int BYTE_SH   = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_line,
  input  logic              rd_cmd_ok,
  input  logic              early_ack_en,
  input  logic              posted_pending,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic              rd_wait,
  output logic              rd_addr_ack,
  output logic              rd_data_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              pci_req,
  input  logic              pci_gnt,
  output logic              pci_cyc,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [1:0]        pci_space,
  output logic [CNT_W-1:0]  pci_count,
  input  logic              pci_rvalid,
  input  logic [DATA_W-1:0] pci_rdata,
  input  logic              pci_disc,
  input  logic              pci_mabort
);

  logic              dec_claim, dec_own;
  spc_e              dec_spc;
  seq_st_e           st;
  logic [6:0]        st_bits;
  logic              col_clear, col_arm, aborted;
  logic [CNT_W-1:0]  wcnt, rcnt, need;
  logic [ADDR_W-1:0] addr_q;
  spc_e              spc_q;
  logic              line_q, own_q, early_q;
  logic [DATA_W-1:0] buf_word;

  rdseq_decode #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dec (
    .addr(rd_addr), .line(rd_line), .cmd_ok(rd_cmd_ok),
    .claim(dec_claim), .own(dec_own), .space(dec_spc)
  );

  rdseq_ctrl #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .dec_claim(dec_claim), .dec_own(dec_own), .dec_spc(dec_spc),
    .rd_addr(rd_addr), .rd_line(rd_line), .early_ack_en(early_ack_en),
    .posted_pending(posted_pending), .pci_gnt(pci_gnt),
    .pci_rvalid(pci_rvalid), .pci_disc(pci_disc), .pci_mabort(pci_mabort),
    .wcnt(wcnt), .aborted(aborted), .st(st),
    .col_clear(col_clear), .col_arm(col_arm),
    .rd_wait(rd_wait), .rd_addr_ack(rd_addr_ack), .ret_vld(rd_data_vld),
    .rcnt(rcnt), .need(need), .addr_q(addr_q), .spc_q(spc_q),
    .line_q(line_q), .own_q(own_q), .early_q(early_q)
  );

  rdseq_collect #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(col_clear), .arm(col_arm), .need(need),
    .pci_rvalid(pci_rvalid), .pci_rdata(pci_rdata), .pci_disc(pci_disc),
    .pci_mabort(pci_mabort), .rd_idx(rcnt[IDX_W-1:0]),
    .active(pci_cyc), .wcnt(wcnt), .aborted(aborted), .rd_word(buf_word)
  );

  assign st_bits   = st;
  assign pci_req   = (st == S_ARB);
  assign pci_space = spc_q;
  assign pci_addr  = addr_q + (ADDR_W'(wcnt) << BYTE_SH);
  assign pci_count = need - wcnt;
  assign rd_data   = aborted ? {DATA_W{1'b1}} : (own_q ? cfg_rdata : buf_word);

endmodule

// File: rtl/rdseq_chk.sv
`timescale 1ns/1ps
module rdseq_chk #(
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = $clog2(LINE_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_wait,
  input logic             rd_addr_ack,
  input logic             rd_data_vld,
  input logic             posted_pending,
  input logic             pci_req,
  input logic             pci_cyc,
  input logic             pci_mabort,
  input logic             line_q,
  input logic             early_q,
  input logic             aborted,
  input logic [CNT_W-1:0] wcnt,
  input logic [6:0]       st_bits
);

  // R1
  claim_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_wait) |-> $past(rd_req));

  // R2
  ack_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_ack |-> $past(rd_wait));

  // R3
  req_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_req) |-> !$past(posted_pending));

  // R4
  full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_ack && line_q && !early_q && !aborted) |-> (wcnt == CNT_W'(LINE_WORDS)));

  // R6
  abort_ends_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_cyc && pci_mabort) |=> !pci_cyc);

  // R9
  data_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_vld |-> (!rd_wait && !rd_addr_ack));

  // R9
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_bits) == 1);

endmodule

bind pci_read_sequencer rdseq_chk #(.LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)) u_rdseq_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_wait(rd_wait),
  .rd_addr_ack(rd_addr_ack), .rd_data_vld(rd_data_vld),
  .posted_pending(posted_pending), .pci_req(pci_req), .pci_cyc(pci_cyc),
  .pci_mabort(pci_mabort), .line_q(line_q), .early_q(early_q),
  .aborted(aborted), .wcnt(wcnt), .st_bits(st_bits)
);

// File: tb/pci_read_sequencer_bench.sv
`timescale 1ns/1ps
module pci_read_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, rd_line, rd_cmd_ok, early_ack_en, posted_pending;
  logic [31:0] rd_addr, cfg_rdata, rd_data, pci_addr, pci_rdata;
  logic        rd_wait, rd_addr_ack, rd_data_vld, pci_req, pci_gnt, pci_cyc;
  logic [1:0]  pci_space;
  logic [3:0]  pci_count;
  logic        pci_rvalid, pci_disc, pci_mabort;

  always #10 clk = ~clk;

  pci_read_sequencer u_pci_read_sequencer (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_line(rd_line), .rd_cmd_ok(rd_cmd_ok), .early_ack_en(early_ack_en),
    .posted_pending(posted_pending), .cfg_rdata(cfg_rdata),
    .rd_wait(rd_wait), .rd_addr_ack(rd_addr_ack), .rd_data_vld(rd_data_vld),
    .rd_data(rd_data), .pci_req(pci_req), .pci_gnt(pci_gnt), .pci_cyc(pci_cyc),
    .pci_addr(pci_addr), .pci_space(pci_space), .pci_count(pci_count),
    .pci_rvalid(pci_rvalid), .pci_rdata(pci_rdata), .pci_disc(pci_disc),
    .pci_mabort(pci_mabort)
  );

  int n_chk = 0;
  int n_fail = 0;

  // target model controls and bookkeeping
  bit          tgt_abort;
  int          tgt_disc;
  int          cyc_beats;
  int          beats_total = 0;
  int          beats_base;
  int          posted_left;
  logic [31:0] cur_base;
  int          cur_need;
  logic [1:0]  exp_spc;
  bit          saw_req, saw_wait, saw_ack, flush_bad, spc_bad, addr_bad;

  function automatic logic [31:0] dat_fn(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic bit claim_fn(logic [31:0] a, bit ln, bit ok);
    logic [3:0] t = a[31:28];
    bit hit = (t == 4'h8) || (t == 4'hE) || (t == 4'hC) || (t == 4'hD) || (t == 4'hF);
    return hit && ok && (!ln || t == 4'h8);
  endfunction

  function automatic logic [1:0] spc_fn(logic [3:0] t);
    case (t)
      4'hE:    return 2'd1;
      4'hC:    return 2'd2;
      4'hD:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && pci_cyc && pci_rvalid) beats_total <= beats_total + 1;
  end

  // PCI target model, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      pci_gnt = 1'b0; pci_rvalid = 1'b0; pci_disc = 1'b0; pci_mabort = 1'b0;
      pci_rdata = '0; cyc_beats = 0;
    end else begin
      pci_rvalid = 1'b0; pci_disc = 1'b0; pci_mabort = 1'b0;
      pci_gnt = pci_req && ($urandom % 2 == 0);
      if (!pci_cyc) cyc_beats = 0;
      else if (tgt_abort) pci_mabort = 1'b1;
      else if ($urandom % 4 != 0) begin
        pci_rvalid = 1'b1;
        pci_rdata  = dat_fn(pci_addr);
        cyc_beats++;
        pci_disc   = (tgt_disc != 0) && (cyc_beats == tgt_disc);
      end
    end
  end

  task automatic tick();
    int done_w;
    @(negedge clk);
    if (pci_req) saw_req = 1'b1;
    if (rd_wait) saw_wait = 1'b1;
    if (rd_addr_ack) saw_ack = 1'b1;
    if (pci_req && posted_pending) flush_bad = 1'b1;
    if (pci_req && pci_space != exp_spc) spc_bad = 1'b1;
    if (pci_cyc) begin
      done_w = beats_total - beats_base;
      if (pci_addr != cur_base + 32'(done_w * 4) || pci_count != 4'(cur_need - done_w))
        addr_bad = 1'b1;
    end
    if (posted_left > 0) posted_left--;
    posted_pending = (posted_left > 0);
  endtask

  task automatic run_read(input logic [31:0] a, input bit ln, input bit ok, input bit early,
                          input bit ab, input int disc, input int posted);
    bit          own = (a[31:28] == 4'hF);
    bit          cl  = claim_fn(a, ln, ok);
    int          need = ln ? 8 : 1;
    int          k;
    int          got;
    logic [31:0] exp;
    string       tag;
    tgt_abort = ab; tgt_disc = disc; early_ack_en = early;
    posted_left = posted; posted_pending = (posted > 0);
    cfg_rdata = $urandom; cur_base = a; cur_need = need; beats_base = beats_total;
    exp_spc = spc_fn(a[31:28]);
    saw_req = 0; saw_wait = 0; saw_ack = 0; flush_bad = 0; spc_bad = 0; addr_bad = 0;
    rd_addr = a; rd_line = ln; rd_cmd_ok = ok; rd_req = 1'b1;
    if (!cl) begin
      repeat (12) tick();
      rd_req = 1'b0;
      // R1: refused read must stay silent
      check(!saw_wait && !saw_ack && !saw_req, "R1", "refused read responded",
            {29'b0, saw_wait, saw_ack, saw_req}, 32'd0);
      return;
    end
    tick();
    check(rd_wait, "R2", "wait in first cycle", {31'b0, rd_wait}, 32'd1);
    k = 0;
    while (!rd_addr_ack && k < 3000) begin tick(); k++; end
    check(rd_addr_ack, "R2", "acknowledge reached", {31'b0, rd_addr_ack}, 32'd1);
    got = beats_total - beats_base;
    if (own) begin
      check(k == 1, "R7", "bridge register ack latency", 32'(k), 32'd1);
      if (posted > 4) check(posted_pending, "R7", "ack with writes posted", {31'b0, posted_pending}, 32'd1);
      check(got == 0, "R7", "no PCI words for bridge register", 32'(got), 32'd0);
    end else if (ln && !ab) begin
      if (early) check(got == 1, "R5", "words before early ack", 32'(got), 32'd1);
      else       check(got == 8, "R4", "words before line ack", 32'(got), 32'd8);
    end
    rd_req = 1'b0;
    for (int i = 0; i < need; i++) begin
      k = 0;
      tick();
      while (!rd_data_vld && k < 3000) begin tick(); k++; end
      exp = own ? cfg_rdata : (ab ? 32'hFFFF_FFFF : dat_fn(a + 32'(4 * i)));
      tag = own ? "R7" : (ab ? "R6" : "R9");
      check(rd_data_vld && rd_data == exp, tag, $sformatf("beat %0d data", i), rd_data, exp);
    end
    tick();
    check(!rd_wait && !rd_data_vld && !rd_addr_ack, "R9", "idle after last beat",
          {29'b0, rd_wait, rd_data_vld, rd_addr_ack}, 32'd0);
    if (!own) begin
      check(!flush_bad, "R3", "bus requested with writes posted", {31'b0, flush_bad}, 32'd0);
      check(!spc_bad, "R10", "space code during request", {31'b0, spc_bad}, 32'd0);
      check(!addr_bad, "R8", "PCI address or count mismatch", {31'b0, addr_bad}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4051));
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; rd_line = 1'b0; rd_cmd_ok = 1'b0;
    early_ack_en = 1'b0; posted_pending = 1'b0; cfg_rdata = '0;
    tgt_abort = 0; tgt_disc = 0; posted_left = 0; cur_base = '0; cur_need = 1;
    beats_base = 0; exp_spc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R9: reset state is idle
    check(!rd_wait && !rd_addr_ack && !rd_data_vld && !pci_req && !pci_cyc, "R9", "reset outputs",
          {27'b0, rd_wait, rd_addr_ack, rd_data_vld, pci_req, pci_cyc}, 32'd0);

    run_read(32'hF000_0010, 0, 1, 0, 0, 0, 20);   // R7 bridge register, writes posted
    run_read(32'h8000_1000, 0, 1, 0, 0, 0, 6);    // R3 single memory after drain
    run_read(32'h8001_0000, 1, 1, 0, 0, 0, 0);    // R4 buffered line
    run_read(32'h8002_0040, 1, 1, 0, 0, 3, 2);    // R8 disconnect and reissue
    run_read(32'h8003_0080, 1, 1, 1, 0, 0, 0);    // R5 early acknowledge
    run_read(32'hE000_0100, 0, 1, 0, 1, 0, 0);    // R6 single abort
    run_read(32'h8004_0000, 1, 1, 0, 1, 0, 3);    // R6 line abort
    run_read(32'h1000_0000, 0, 1, 0, 0, 0, 0);    // R1 unmapped tag
    run_read(32'h8000_2000, 0, 0, 0, 0, 0, 0);    // R1 unsupported command
    run_read(32'hE000_0200, 1, 1, 0, 0, 0, 0);    // R1 line outside memory
    run_read(32'hC000_0300, 0, 1, 0, 0, 0, 0);    // R10 configuration space
    run_read(32'hD000_0000, 0, 1, 0, 0, 0, 0);    // R10 interrupt acknowledge

    for (int n = 0; n < 40; n++) begin
      logic [3:0] tg;
      bit ln, ok, early, ab;
      int disc, posted;
      case ($urandom % 6)
        0: tg = 4'h8; 1: tg = 4'hE; 2: tg = 4'hC;
        3: tg = 4'hD; 4: tg = 4'hF; default: tg = 4'h3;
      endcase
      if ($urandom % 3 == 0) tg = 4'h8;
      ln     = ($urandom % 2) == 1;
      ok     = ($urandom % 8) != 0;
      early  = ln && (($urandom % 2) == 1);
      ab     = ($urandom % 6) == 0;
      disc   = (ln && !early && !ab) ? int'($urandom % 5) : 0;
      posted = ($urandom % 4 == 0) ? int'($urandom % 8) : 0;
      run_read({tg, 23'($urandom), 5'b0}, ln, ok, early, ab, disc, posted);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule